// File: doc/BRIEF.md
# Paged Fetch Address Sequencer

This block produces the instruction fetch address for a program store of 2048 words, arranged as 16 pages of 128 words each. The address is the 4-bit current page followed by a 7-bit in-page counter. The instruction decoder drives one step per instruction through a set of strobes: sequential advance, page buffer write, branch, call and return. A 7-bit target, a 4-bit page value and the processor's single status bit go with the strobes.

Control flow only leaves a page through the page buffer. A page-buffer write stages the destination page. A branch or call that is taken then moves the staged page into the current page and loads the counter from the target. Branches and calls are taken only while the status bit is 1. Return addresses live in one slot. A call made while that slot is in use becomes a plain branch, so subroutines cannot nest.

Top module: `paged_fetch_seq`

## Requirements
- R1: While reset is held and at the first step after it, the fetch address is page 15, counter 0 (0x780). The page buffer also resets to 15, so a taken branch before any buffer write stays on page 15.
- R2: A sequential advance adds one to the counter, modulo 128. The counter goes from 127 back to 0 and the current page does not change.
- R3: A buffer write stores the 4-bit page value in the page buffer. A taken branch sets the current page from the buffer and the counter from the 7-bit target.
- R4: A branch or call made while the status bit is 0 only advances the counter as in R2. The page, the buffer and the return slot are left as they were.
- R5: A taken call made while the return slot is empty stores the current page and the counter plus one (modulo 128, same page) in the slot and marks the slot in use. It then jumps as a taken branch does.
- R6: A taken call made while the slot is in use acts as a taken branch and leaves the stored return address unchanged.
- R7: A return while the slot is in use loads the page and the counter from the slot and marks the slot empty.
- R8: A return while the slot is empty only advances the counter.
- R9: When several strobes are set in one step, return wins over call, call over branch and branch over advance. A step with none of these strobes holds the address. A buffer write may come with any of them. A taken branch or call in that same step uses the buffer value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_i | input | 1 | Sequential advance strobe |
| ldp_i | input | 1 | Page buffer write strobe |
| br_i | input | 1 | Conditional branch strobe |
| call_i | input | 1 | Conditional call strobe |
| ret_i | input | 1 | Return strobe |
| status_i | input | 1 | Status bit; 1 allows branch and call to be taken |
| tgt_i | input | 7 | In-page target for branch and call |
| pgval_i | input | 4 | Value written to the page buffer |
| fetch_addr_o | output | 11 | Fetch address {page, counter} |

## Verification
On every cycle the assertions check the reset address, wrapping within the page, fall-through when the status bit is 0, branch targets built from the held buffer, the slot keeping its contents on a nested call, the slot emptying on return, and the address holding when idle. Some behaviour is only visible in the bench's scenarios, because it shows up steps later at the ports. These are the return address stored by a call at counter 127 and the second return after a nested call, which only advances. The buffer-write ordering also needs a later branch to show which page was kept. A long pseudo-random strobe sequence compared against the behavioural model covers the mixed-priority cases.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
    typedef enum logic [2:0] {
        OP_IDLE = 3'd0,
        OP_ADV  = 3'd1,
        OP_BR   = 3'd2,
        OP_CALL = 3'd3,
        OP_RET  = 3'd4
    } pfs_op_e;
endpackage

// File: rtl/pfs_op_decode.sv
module pfs_op_decode
    import pfs_pkg::*;
(
    input  logic    adv_i,
    input  logic    br_i,
    input  logic    call_i,
    input  logic    ret_i,
    output pfs_op_e op_o
);
    // Fixed priority: return, call, branch, advance
    always_comb begin
        if (ret_i)       op_o = OP_RET;
        else if (call_i) op_o = OP_CALL;
        else if (br_i)   op_o = OP_BR;
        else if (adv_i)  op_o = OP_ADV;
        else             op_o = OP_IDLE;
    end
endmodule

// File: rtl/pfs_pc_step.sv
module pfs_pc_step #(
    parameter int PC_W = 7
) (
    input  logic [PC_W-1:0] pc_i,
    output logic [PC_W-1:0] pc_inc_o
);
    // Natural width overflow keeps the counter inside its page
    always_comb pc_inc_o = pc_i + PC_W'(1);
endmodule

// File: rtl/paged_fetch_seq.sv
module paged_fetch_seq
    import pfs_pkg::*;
#(
    parameter int PC_W       = 7,
    parameter int PG_W       = 4,
    parameter int RESET_PAGE = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv_i,
    input  logic                 ldp_i,
    input  logic                 br_i,
    input  logic                 call_i,
    input  logic                 ret_i,
    input  logic                 status_i,
    input  logic [PC_W-1:0]      tgt_i,
    input  logic [PG_W-1:0]      pgval_i,
    output logic [PG_W+PC_W-1:0] fetch_addr_o
);
    localparam logic [PG_W-1:0] PG_RST = PG_W'(RESET_PAGE);

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [PG_W-1:0] pg;
        logic [PG_W-1:0] pbuf;
        logic            sv;
        logic [PC_W-1:0] spc;
        logic [PG_W-1:0] spg;
    } seq_st_t;

    seq_st_t         st_d, st_q;
    pfs_op_e         op;
    logic [PC_W-1:0] pc_inc;

    pfs_op_decode u_dec (
        .adv_i  (adv_i),
        .br_i   (br_i),
        .call_i (call_i),
        .ret_i  (ret_i),
        .op_o   (op)
    );

    pfs_pc_step #(.PC_W(PC_W)) u_step (
        .pc_i     (st_q.pc),
        .pc_inc_o (pc_inc)
    );

    always_comb begin
        st_d = st_q;
        if (ldp_i) st_d.pbuf = pgval_i;
        unique case (op)
            OP_ADV: st_d.pc = pc_inc;
            OP_BR: begin
                if (status_i) begin
                    st_d.pg = st_q.pbuf;
                    st_d.pc = tgt_i;
                end else begin
                    st_d.pc = pc_inc;
                end
            end
            OP_CALL: begin
                if (status_i) begin
                    if (!st_q.sv) begin
                        st_d.sv  = 1'b1;
                        st_d.spc = pc_inc;
                        st_d.spg = st_q.pg;
                    end
                    st_d.pg = st_q.pbuf;
                    st_d.pc = tgt_i;
                end else begin
                    st_d.pc = pc_inc;
                end
            end
            OP_RET: begin
                if (st_q.sv) begin
                    st_d.pc = st_q.spc;
                    st_d.pg = st_q.spg;
                    st_d.sv = 1'b0;
                end else begin
                    st_d.pc = pc_inc;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pc   <= '0;
            st_q.pg   <= PG_RST;
            st_q.pbuf <= PG_RST;
            st_q.sv   <= 1'b0;
            st_q.spc  <= '0;
            st_q.spg  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_addr_o = {st_q.pg, st_q.pc};
endmodule

// File: rtl/pfs_checker.sv
module pfs_checker #(
    parameter int PC_W       = 7,
    parameter int PG_W       = 4,
    parameter int RESET_PAGE = 15
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 adv_i,
    input logic                 br_i,
    input logic                 call_i,
    input logic                 ret_i,
    input logic                 status_i,
    input logic [PC_W-1:0]      tgt_i,
    input logic [PG_W-1:0]      pbuf,
    input logic                 sv,
    input logic [PC_W-1:0]      spc,
    input logic [PG_W-1:0]      spg,
    input logic [PG_W+PC_W-1:0] fetch_addr_o
);
    localparam logic [PG_W+PC_W-1:0] ADDR_RST = {PG_W'(RESET_PAGE), PC_W'(0)};

    logic [PC_W-1:0] pc_o;
    logic [PG_W-1:0] pg_o;
    assign pc_o = fetch_addr_o[PC_W-1:0];
    assign pg_o = fetch_addr_o[PC_W +: PG_W];

    a_r1_reset_addr: assert property (@(posedge clk)
        !rst_n |=> fetch_addr_o == ADDR_RST);

    a_r2_adv_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !br_i && !call_i && !ret_i) |=>
        (pg_o == $past(pg_o)) && (pc_o == PC_W'($past(pc_o) + 1)));

    a_r3_branch_target: assert property (@(posedge clk) disable iff (!rst_n)
        (br_i && status_i && !call_i && !ret_i) |=>
        fetch_addr_o == {$past(pbuf), $past(tgt_i)});

    a_r4_fall_through: assert property (@(posedge clk) disable iff (!rst_n)
        ((br_i || call_i) && !ret_i && !status_i) |=>
        (pg_o == $past(pg_o)) && (pc_o == PC_W'($past(pc_o) + 1)));

    a_r6_slot_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i && status_i && sv) |=>
        sv && $stable(spc) && $stable(spg));

    a_r7_ret_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && sv) |=> !sv && fetch_addr_o == {$past(spg), $past(spc)});

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !br_i && !call_i && !ret_i) |=> $stable(fetch_addr_o));
endmodule

bind paged_fetch_seq pfs_checker #(
    .PC_W(PC_W), .PG_W(PG_W), .RESET_PAGE(RESET_PAGE)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .adv_i        (adv_i),
    .br_i         (br_i),
    .call_i       (call_i),
    .ret_i        (ret_i),
    .status_i     (status_i),
    .tgt_i        (tgt_i),
    .pbuf         (st_q.pbuf),
    .sv           (st_q.sv),
    .spc          (st_q.spc),
    .spg          (st_q.spg),
    .fetch_addr_o (fetch_addr_o)
);

// File: tb/paged_fetch_seq_tb.sv
`timescale 1ns/1ps
module paged_fetch_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adv_i = 0, ldp_i = 0, br_i = 0, call_i = 0, ret_i = 0, status_i = 0;
    logic [6:0]  tgt_i = '0;
    logic [3:0]  pgval_i = '0;
    logic [10:0] fetch_addr_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // behavioural reference state
    int m_pc, m_pg, m_buf, m_ra_pc, m_ra_pg;
    bit m_sv;

    always #2.5 clk = ~clk;

    paged_fetch_seq dut_i (
        .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .ldp_i(ldp_i), .br_i(br_i),
        .call_i(call_i), .ret_i(ret_i), .status_i(status_i), .tgt_i(tgt_i),
        .pgval_i(pgval_i), .fetch_addr_o(fetch_addr_o)
    );

    task automatic check(input string tag, input int exp);
        n_chk++;
        if (int'(fetch_addr_o) != exp) begin
            n_fail++;
            $display("FAIL %s: addr got 0x%0h expected 0x%0h", tag, fetch_addr_o, exp);
        end
    endtask

    task automatic model(input bit a, l, b, c, r, s, input int t, p);
        int old_buf = m_buf;
        int nxt = (m_pc + 1) % 128;
        if (l) m_buf = p;
        if (r) begin
            if (m_sv) begin m_pc = m_ra_pc; m_pg = m_ra_pg; m_sv = 0; end
            else m_pc = nxt;
        end else if (c) begin
            if (s) begin
                if (!m_sv) begin m_sv = 1; m_ra_pc = nxt; m_ra_pg = m_pg; end
                m_pg = old_buf; m_pc = t;
            end else m_pc = nxt;
        end else if (b) begin
            if (s) begin m_pg = old_buf; m_pc = t; end
            else m_pc = nxt;
        end else if (a) begin
            m_pc = nxt;
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input bit a, l, b, c, r, s, input int t, p, input string tag);
        adv_i = a; ldp_i = l; br_i = b; call_i = c; ret_i = r; status_i = s;
        tgt_i = 7'(t); pgval_i = 4'(p);
        @(posedge clk);
        model(a, l, b, c, r, s, t, p);
        @(negedge clk);
        check(tag, m_pg * 128 + m_pc);
    endtask

    task automatic do_reset();
        rst_n = 0;
        adv_i = 0; ldp_i = 0; br_i = 0; call_i = 0; ret_i = 0;
        repeat (2) @(negedge clk);
        m_pc = 0; m_pg = 15; m_buf = 15; m_sv = 0; m_ra_pc = 0; m_ra_pg = 0;
        check("R1", 'h780);
        rst_n = 1;
    endtask

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int lcg;
        do_reset();
        // R1: buffer resets to 15, so a taken branch stays on page 15
        step(0,0,1,0,0,1, 5, 0, "R1");
        // R2: advance across the page end
        for (int i = 0; i < 130; i++) step(1,0,0,0,0,0, 0, 0, "R2");
        // R3: stage page 3, then branch there
        step(1,1,0,0,0,0, 0, 3, "R3");
        step(0,0,1,0,0,1, 10, 0, "R3");
        // R4: status 0 falls through for branch and call
        step(0,0,1,0,0,0, 99, 0, "R4");
        step(0,0,0,1,0,0, 99, 0, "R4");
        // R5 call, R6 nested call, R7 return, R8 empty return
        step(1,1,0,0,0,0, 0, 6, "R3");
        step(0,0,0,1,0,1, 20, 0, "R5");
        step(1,1,0,0,0,0, 0, 9, "R3");
        step(0,0,0,1,0,1, 40, 0, "R6");
        step(1,0,0,0,0,0, 0, 0, "R2");
        step(0,0,0,0,1,0, 0, 0, "R7");
        step(0,0,0,0,1,0, 0, 0, "R8");
        // R5 at counter 127: return address wraps within the page
        step(0,0,1,0,0,1, 127, 0, "R3");
        step(0,0,0,1,0,1, 64, 0, "R5");
        step(0,0,0,0,1,1, 0, 0, "R7");
        // R9: priority and idle hold
        step(1,0,1,1,1,1, 33, 0, "R9");
        step(0,0,0,0,0,1, 77, 0, "R9");
        step(0,0,0,0,0,0, 0, 0, "R9");
        step(1,0,1,1,0,1, 50, 0, "R9");
        step(1,0,1,0,0,1, 60, 0, "R9");
        step(0,1,1,0,0,1, 70, 2, "R9");
        step(0,0,1,0,0,1, 71, 0, "R9");
        // mixed pseudo-random strobes against the model
        lcg = 12345;
        for (int i = 0; i < 400; i++) begin
            lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
            step(lcg[3], lcg[4], lcg[5], lcg[6] & lcg[7], lcg[8] & lcg[9], lcg[10],
                 (lcg >> 11) & 127, (lcg >> 18) & 15, "R9");
        end
        // reset again mid-run with slot in use
        step(0,0,0,1,0,1, 3, 0, "R5");
        do_reset();
        step(0,0,0,0,1,0, 0, 0, "R8");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule